// File: doc/BRIEF.md
# Back-to-Front Command Queue with Completion Fence

This block carries commands from a processor back end to its front end. The back end writes commands (an opcode, a sub-code and an address operand) into a small FIFO through a ready->valid port. When the queue is full, `cmd_ready_o` is low and the sender must hold its command until space frees up. No command is ever dropped. There is no clear input; only reset empties the queue.

On the consumer side, the head entry is shown to the front end through `exec_*`. A correct-prediction feedback command leaves the head in the same cycle it appears there. Every other command stays at the head until the front end pulses `exec_done_i`; that pulse acts as the consumer's ready. Commands that redirect the fetch address or replace shadow state raise a one-cycle flush of the separate fetch-output queue when they first reach the head. The fence output tells the back end that every command it sent has been absorbed. The fence is high only when the queue is empty and no command is still settling. It stays low for `FENCE_LAG` cycles after a non-feedback command retires, while feedback commands add no such wait. After reset the front end is quiescent: `fetch_en_o` stays low until a state-reset command has been processed.

Top module: `cmdq_fence`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `cmd_ready_o` is 1, and `exec_valid_o`, `fetch_flush_o` and `fetch_en_o` are 0. `fence_o` is 1.
- R2: When `DEPTH` entries are held, `cmd_ready_o` is 0 and an offered command is not taken. It is taken at the first clock edge after a retirement frees a slot. No command is lost.
- R3: A command whose opcode is not 3 stays at the head with unchanged fields until a clock edge at which `exec_done_i` is 1. It then leaves the queue at that edge.
- R4: `fence_o` is 0 in every cycle in which an entry is held. After a non-feedback command retires, `fence_o` stays 0 for `FENCE_LAG` more cycles, even when the queue is empty.
- R5: A feedback command (opcode 3) leaves at the first clock edge after it appears at the head, whatever `exec_done_i` is. It adds no fence lag.
- R6: `fetch_flush_o` is 1 for exactly one cycle per command with opcode 0 (state reset) or 1 (redirect). That cycle is the first cycle the command is at the head. The flush is never raised for opcodes 2 (icache fence), 3, 4 (TLB fill) or 5 (TLB fence).
- R7: Commands reach the head in the order they were accepted. Each carries the sub-code and address it was written with.
- R8: `fetch_en_o` is 0 from reset until the clock edge at which an opcode-0 command retires. From then on it stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Back end offers a command |
| cmd_ready_o | output | 1 | Queue can take a command this cycle |
| cmd_op_i | input | 3 | Command opcode |
| cmd_sub_i | input | SUB_W | Command sub-code |
| cmd_addr_i | input | ADDR_W | Address operand |
| exec_valid_o | output | 1 | A command is at the head |
| exec_op_o | output | 3 | Opcode of the head command |
| exec_sub_o | output | SUB_W | Sub-code of the head command |
| exec_addr_o | output | ADDR_W | Address of the head command |
| exec_done_i | input | 1 | Front end has finished processing the head command |
| fetch_flush_o | output | 1 | One-cycle flush request for the fetch-output queue |
| fetch_en_o | output | 1 | Front end may fetch |
| fence_o | output | 1 | All commands absorbed and processed |

## Verification
The bench builds the block with `DEPTH`=4, `ADDR_W`=8, `SUB_W`=3 and `FENCE_LAG`=2. With these values a full queue takes only four pushes, and each fence-lag window spans just two cycles. The bench sweeps every defined opcode against completion delays of zero to three cycles, starting from an empty queue. It also fills the queue past capacity with a fifth command held back, and it sends a back-to-back burst of feedback commands. These runs cover single-cycle retirement, a long hold at the head, the backpressure boundary and the no-lag path.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  typedef enum logic [2:0] {
    OP_STATE_RESET = 3'd0,
    OP_REDIRECT    = 3'd1,
    OP_ICACHE_FENCE = 3'd2,
    OP_FEEDBACK    = 3'd3,
    OP_TLB_FILL    = 3'd4,
    OP_TLB_FENCE   = 3'd5
  } cmd_op_e;

  localparam int OP_W = 3;

  function automatic logic op_flushes(input logic [OP_W-1:0] op);
    return (op == OP_STATE_RESET) || (op == OP_REDIRECT);
  endfunction

  function automatic logic op_is_feedback(input logic [OP_W-1:0] op);
    return op == OP_FEEDBACK;
  endfunction

endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  assign full  = (count == CAP);
  assign empty = (count == '0);
  assign dout  = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl
  import cmdq_pkg::*;
#(
  parameter int FENCE_LAG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            head_valid,
  input  logic [OP_W-1:0] head_op,
  input  logic            done,
  output logic            pop,
  output logic            flush,
  output logic            fetch_en,
  output logic            fence
);
  localparam int LAG_W = $clog2(FENCE_LAG + 2);
  localparam logic [LAG_W-1:0] LAG_LOAD = LAG_W'(FENCE_LAG);

  logic             started;
  logic [LAG_W-1:0] lag;
  logic             fb_head;
  logic             retire_work;

  assign fb_head     = head_valid && op_is_feedback(head_op);
  assign pop         = fb_head || (head_valid && done);
  assign retire_work = pop && !fb_head;
  assign flush       = head_valid && !started && op_flushes(head_op);
  assign fence       = !head_valid && (lag == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started  <= 1'b0;
      lag      <= '0;
      fetch_en <= 1'b0;
    end else begin
      if (pop)             started <= 1'b0;
      else if (head_valid) started <= 1'b1;

      if (retire_work)     lag <= LAG_LOAD;
      else if (lag != '0)  lag <= lag - 1'b1;

      if (retire_work && head_op == OP_STATE_RESET) fetch_en <= 1'b1;
    end
  end
endmodule

// File: rtl/cmdq_fence.sv
module cmdq_fence
  import cmdq_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int ADDR_W    = 39,
  parameter int SUB_W     = 3,
  parameter int FENCE_LAG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [OP_W-1:0]   cmd_op_i,
  input  logic [SUB_W-1:0]  cmd_sub_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  output logic              exec_valid_o,
  output logic [OP_W-1:0]   exec_op_o,
  output logic [SUB_W-1:0]  exec_sub_o,
  output logic [ADDR_W-1:0] exec_addr_o,
  input  logic              exec_done_i,
  output logic              fetch_flush_o,
  output logic              fetch_en_o,
  output logic              fence_o
);
  localparam int ENTRY_W = OP_W + SUB_W + ADDR_W;

  logic               q_full, q_empty, head_pop;
  logic [ENTRY_W-1:0] q_head;

  cmdq_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (cmd_valid_i),
    .din   ({cmd_op_i, cmd_sub_i, cmd_addr_i}),
    .full  (q_full),
    .pop   (head_pop),
    .dout  (q_head),
    .empty (q_empty)
  );

  assign cmd_ready_o  = !q_full;
  assign exec_valid_o = !q_empty;
  assign {exec_op_o, exec_sub_o, exec_addr_o} = q_head;

  cmdq_ctrl #(.FENCE_LAG(FENCE_LAG)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_valid (!q_empty),
    .head_op    (q_head[ENTRY_W-1 -: OP_W]),
    .done       (exec_done_i),
    .pop        (head_pop),
    .flush      (fetch_flush_o),
    .fetch_en   (fetch_en_o),
    .fence      (fence_o)
  );
endmodule

// File: rtl/cmdq_fence_chk.sv
module cmdq_fence_chk #(
  parameter int ADDR_W = 39,
  parameter int SUB_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready_o,
  input logic              exec_valid_o,
  input logic [2:0]        exec_op_o,
  input logic [SUB_W-1:0]  exec_sub_o,
  input logic [ADDR_W-1:0] exec_addr_o,
  input logic              exec_done_i,
  input logic              fetch_flush_o,
  input logic              fetch_en_o,
  input logic              fence_o,
  input logic              head_pop
);
  assert_no_accept_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready_o |-> exec_valid_o);

  assert_hold_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid_o && exec_op_o != 3'd3 && !exec_done_i) |=>
      (exec_valid_o && $stable({exec_op_o, exec_sub_o, exec_addr_o})));

  assert_fence_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fence_o |-> !exec_valid_o);

  assert_feedback_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid_o && exec_op_o == 3'd3) |-> head_pop);

  assert_flush_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_flush_o |-> (exec_valid_o && (exec_op_o == 3'd0 || exec_op_o == 3'd1)));

  assert_fetch_en_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en_o |=> fetch_en_o);
endmodule

bind cmdq_fence cmdq_fence_chk #(.ADDR_W(ADDR_W), .SUB_W(SUB_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_ready_o   (cmd_ready_o),
  .exec_valid_o  (exec_valid_o),
  .exec_op_o     (exec_op_o),
  .exec_sub_o    (exec_sub_o),
  .exec_addr_o   (exec_addr_o),
  .exec_done_i   (exec_done_i),
  .fetch_flush_o (fetch_flush_o),
  .fetch_en_o    (fetch_en_o),
  .fence_o       (fence_o),
  .head_pop      (head_pop)
);

// File: tb/sim_cmdq_fence.sv
module sim_cmdq_fence;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 4;
  localparam int ADDR_W = 8;
  localparam int SUB_W  = 3;
  localparam int LAG    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [SUB_W-1:0] cmd_sub = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic exec_valid;
  logic [2:0] exec_op;
  logic [SUB_W-1:0] exec_sub;
  logic [ADDR_W-1:0] exec_addr;
  logic done = 1'b0;
  logic flush, fetch_en, fence;

  int n_cmp = 0;
  int n_bad = 0;
  bit exp_en = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdq_fence #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SUB_W(SUB_W), .FENCE_LAG(LAG)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_sub_i(cmd_sub), .cmd_addr_i(cmd_addr),
    .exec_valid_o(exec_valid), .exec_op_o(exec_op), .exec_sub_o(exec_sub),
    .exec_addr_o(exec_addr), .exec_done_i(done),
    .fetch_flush_o(flush), .fetch_en_o(fetch_en), .fence_o(fence)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic one_cmd(input int op, input int dly, input int addr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op[2:0]; cmd_sub = dly[SUB_W-1:0]; cmd_addr = addr[ADDR_W-1:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R3 head shown", int'(exec_valid), 1);
    chk("R7 head op", int'(exec_op), op);
    chk("R7 head sub", int'(exec_sub), dly);
    chk("R7 head addr", int'(exec_addr), addr);
    chk("R4 fence low with entry", int'(fence), 0);
    chk("R6 flush on first head cycle", int'(flush), (op <= 1) ? 1 : 0);
    if (op == 3) begin
      @(negedge clk);
      chk("R5 feedback retired at once", int'(exec_valid), 0);
      chk("R5 fence without lag", int'(fence), 1);
      chk("R6 no flush after", int'(flush), 0);
    end else begin
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        chk("R3 held until done", int'(exec_valid), 1);
        chk("R3 addr stable", int'(exec_addr), addr);
        chk("R6 single flush cycle", int'(flush), 0);
        chk("R4 fence low while held", int'(fence), 0);
      end
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      if (op == 0) exp_en = 1'b1;
      chk("R3 retired on done", int'(exec_valid), 0);
      chk("R8 fetch enable", int'(fetch_en), int'(exp_en));
      for (int i = 0; i < LAG; i++) begin
        chk("R4 fence lag", int'(fence), 0);
        @(negedge clk);
      end
      chk("R4 fence after lag", int'(fence), 1);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 fence in reset", int'(fence), 1);
    chk("R1 ready in reset", int'(cmd_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", int'(cmd_ready), 1);
    chk("R1 no head", int'(exec_valid), 0);
    chk("R1 no flush", int'(flush), 0);
    chk("R1 quiescent", int'(fetch_en), 0);
    chk("R1 fence", int'(fence), 1);

    for (int k = 0; k < 6; k++)
      for (int d = 0; d < 4; d++)
        one_cmd((k + 1) % 6, d, k * 4 + d);

    // R2 / R7: fill past capacity
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd2; cmd_sub = '0; cmd_addr = ADDR_W'(100 + i);
    end
    @(negedge clk);
    chk("R2 ready low when full", int'(cmd_ready), 0);
    cmd_addr = ADDR_W'(100 + DEPTH);
    @(negedge clk);
    chk("R2 still full", int'(cmd_ready), 0);
    chk("R7 head is oldest", int'(exec_addr), 100);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R2 slot freed", int'(cmd_ready), 1);
    chk("R7 next head", int'(exec_addr), 101);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int j = 1; j <= DEPTH; j++) begin
      chk("R2 no loss, R7 order", int'(exec_addr), 100 + j);
      chk("R4 fence low while held", int'(fence), 0);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
    end
    chk("R2 drained", int'(exec_valid), 0);
    repeat (LAG) @(negedge clk);
    chk("R4 fence after drain", int'(fence), 1);

    // R5: back-to-back feedback burst
    cmd_valid = 1'b1; cmd_op = 3'd3; cmd_addr = ADDR_W'(200);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 burst head", int'(exec_addr), 200 + i);
      chk("R4 fence low in burst", int'(fence), 0);
      if (i < 2) cmd_addr = ADDR_W'(201 + i);
      else cmd_valid = 1'b0;
    end
    @(negedge clk);
    chk("R5 burst drained", int'(exec_valid), 0);
    chk("R5 fence no lag after burst", int'(fence), 1);
    chk("R8 enable kept", int'(fetch_en), 1);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      summary();
      $finish;
    end
  end
endmodule